// File: doc/BRIEF.md
# Remote Critical Section Request Queue

This block is the call queue in front of one accelerator core. Small cores send it requests to run a critical section remotely. Each request names a lock, a target program counter, the caller's stack pointer and the caller's core index. The queue holds one slot per small core. It hands requests to the accelerator one at a time, in the order they arrived. When the accelerator reports that the work is finished, the queue returns a done response to the core that made the call.

The queue also watches for false serialization. This happens when a call has to wait behind work for a different lock. Each lock has its own 4-bit saturating score. A request that arrived while a slot for another lock was occupied raises its lock's score when it is dispatched. A request that arrived with no other lock present lowers its lock's score. When a lock's score reaches a threshold, the queue stops taking calls for that lock and tells the caller to run the section itself.

The request, dispatch, completion and done paths each use a valid/ready handshake. A transfer takes place on a rising clock edge where both valid and ready are high. A valid signal may not depend on its ready. Once raised, a valid signal and its fields stay unchanged until the transfer.

Top module: `cs_request_queue`

## Requirements
- R1: After reset, `disp_valid` and `done_valid` are low, every core sees `req_ready` high, and `req_local` is low for every lock.
- R2: `req_ready` is high only while the slot of the core named on `req_core` is empty. A slot becomes occupied when its request is accepted. It is released only by the done handshake for that core, so it stays occupied while the request is being executed.
- R3: Queued requests are dispatched in the order they were accepted, whatever their core indices.
- R4: A dispatch carries the lock, PC, stack pointer and core index of the request it belongs to, unchanged.
- R5: While `disp_valid` is high and `disp_ready` is low, `disp_valid` stays high and the dispatch fields stay unchanged.
- R6: After a dispatch handshake, `disp_valid` stays low until the completion handshake, even if other requests are queued.
- R7: `done_valid` is high only while the accelerator presents `cmpl_valid` for an outstanding dispatch. `done_core` equals the core index of that dispatch. `cmpl_ready` follows `done_ready`.
- R8: Each lock has a 4-bit score that starts at 0. A request is flagged if, when it is accepted, some occupied slot holds a different lock. When a request is dispatched, its lock's score goes up by 1 if the request is flagged and down by 1 otherwise. The score stays within 0 to 15 and does not wrap.
- R9: `req_local` is high when the score of the lock on `req_lock` is at least `FS_LIMIT`. A request presented with `req_local` high completes its handshake but is not queued, dispatched or answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Call request valid |
| req_ready | output | 1 | Slot of `req_core` is free |
| req_local | output | 1 | Lock on `req_lock` is disabled; the caller runs the section itself |
| req_lock | input | LOCK_W | Lock identifier of the call |
| req_pc | input | PC_W | Target program counter |
| req_sp | input | SP_W | Caller stack pointer |
| req_core | input | CORE_W | Caller core index |
| disp_valid | output | 1 | Dispatch to accelerator valid |
| disp_ready | input | 1 | Accelerator takes the dispatch |
| disp_lock | output | LOCK_W | Lock of the dispatched call |
| disp_pc | output | PC_W | Target PC of the dispatched call |
| disp_sp | output | SP_W | Stack pointer of the dispatched call |
| disp_core | output | CORE_W | Caller of the dispatched call |
| cmpl_valid | input | 1 | Accelerator has finished the current call |
| cmpl_ready | output | 1 | Completion accepted |
| done_valid | output | 1 | Done response valid |
| done_ready | input | 1 | Done response taken by the network |
| done_core | output | CORE_W | Destination core of the done response |

## Verification
Several cores call in a scrambled index order. This shows that the queue keeps arrival order and does not serve cores by their index. A hold phase with `disp_ready` low, and a probe of the caller's slot while its request is executing, show the difference between slot release at dispatch and at completion. Paired calls with different locks drive one lock's score up while lone calls drive another's down from zero. The bench checks that the disable decision flips at exactly the threshold. A pattern that mixes raising and lowering rounds separates a true up/down score from a count that only rises. The lone-lock case shows whether the score wraps below zero.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int FS_CTR_W = 4;
  localparam int FS_CTR_MAX = (1 << FS_CTR_W) - 1;
  typedef logic [FS_CTR_W-1:0] fs_score_t;
endpackage

// File: rtl/cs_order_fifo.sv
module cs_order_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_en,
  input  logic [W-1:0] push_data,
  input  logic         pop_en,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_en) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= bump(wr_ptr);
      end
      if (pop_en) rd_ptr <= bump(rd_ptr);
      case ({push_en, pop_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en) |-> (count < CNT_W'(DEPTH)));

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !empty);
endmodule

// File: rtl/cs_fs_scores.sv
module cs_fs_scores
  import cs_pkg::*;
#(
  parameter int LOCK_W = 4,
  parameter int FS_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [LOCK_W-1:0] upd_lock,
  input  logic              upd_up,
  input  logic [LOCK_W-1:0] q_lock,
  output logic              q_disabled
);
  localparam int NUM_LOCKS = 1 << LOCK_W;

  fs_score_t score [NUM_LOCKS];

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_score
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        score[g] <= '0;
      end else if (upd_en && upd_lock == LOCK_W'(g)) begin
        if (upd_up) begin
          if (score[g] != fs_score_t'(FS_CTR_MAX)) score[g] <= score[g] + 1'b1;
        end else if (score[g] != '0) begin
          score[g] <= score[g] - 1'b1;
        end
      end
    end
  end

  assign q_disabled = (int'(score[q_lock]) >= FS_LIMIT);

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_up && score[upd_lock] == fs_score_t'(FS_CTR_MAX))
      |=> (score[$past(upd_lock)] == fs_score_t'(FS_CTR_MAX)));

  // R8
  sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_up && score[upd_lock] == '0)
      |=> (score[$past(upd_lock)] == '0));
endmodule

// File: rtl/cs_request_queue.sv
module cs_request_queue
  import cs_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LOCK_W = 4,
  parameter int PC_W = 16,
  parameter int SP_W = 16,
  parameter int FS_LIMIT = 8,
  parameter int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              req_local,
  input  logic [LOCK_W-1:0] req_lock,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [SP_W-1:0]   req_sp,
  input  logic [CORE_W-1:0] req_core,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [LOCK_W-1:0] disp_lock,
  output logic [PC_W-1:0]   disp_pc,
  output logic [SP_W-1:0]   disp_sp,
  output logic [CORE_W-1:0] disp_core,
  input  logic              cmpl_valid,
  output logic              cmpl_ready,
  output logic              done_valid,
  input  logic              done_ready,
  output logic [CORE_W-1:0] done_core
);
  logic [LOCK_W-1:0] slot_lock [NUM_CORES];
  logic [PC_W-1:0]   slot_pc   [NUM_CORES];
  logic [SP_W-1:0]   slot_sp   [NUM_CORES];
  logic [NUM_CORES-1:0] occupied;
  logic [NUM_CORES-1:0] slot_flag;

  logic              busy;
  logic [CORE_W-1:0] cur_core;
  logic [CORE_W-1:0] head_core;
  logic              fifo_empty;
  logic              other_lock_present;
  logic              accept, dispatch, complete;

  // A call has to wait behind other work if any occupied slot holds a different lock.
  always_comb begin
    other_lock_present = 1'b0;
    for (int c = 0; c < NUM_CORES; c++)
      if (occupied[c] && slot_lock[c] != req_lock) other_lock_present = 1'b1;
  end

  assign req_ready = !occupied[req_core];
  assign accept    = req_valid && req_ready && !req_local;

  assign disp_valid = !fifo_empty && !busy;
  assign disp_core  = head_core;
  assign disp_lock  = slot_lock[head_core];
  assign disp_pc    = slot_pc[head_core];
  assign disp_sp    = slot_sp[head_core];
  assign dispatch   = disp_valid && disp_ready;

  assign done_valid = cmpl_valid && busy;
  assign cmpl_ready = done_ready && busy;
  assign done_core  = cur_core;
  assign complete   = cmpl_valid && cmpl_ready;

  cs_order_fifo #(.DEPTH(NUM_CORES), .W(CORE_W)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (accept),
    .push_data (req_core),
    .pop_en    (dispatch),
    .head      (head_core),
    .empty     (fifo_empty)
  );

  cs_fs_scores #(.LOCK_W(LOCK_W), .FS_LIMIT(FS_LIMIT)) u_scores (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (dispatch),
    .upd_lock   (disp_lock),
    .upd_up     (slot_flag[head_core]),
    .q_lock     (req_lock),
    .q_disabled (req_local)
  );

  always_ff @(posedge clk) begin
    if (accept) begin
      slot_lock[req_core] <= req_lock;
      slot_pc[req_core]   <= req_pc;
      slot_sp[req_core]   <= req_sp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupied  <= '0;
      slot_flag <= '0;
      busy      <= 1'b0;
      cur_core  <= '0;
    end else begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (accept && req_core == CORE_W'(c)) begin
          occupied[c]  <= 1'b1;
          slot_flag[c] <= other_lock_present;
        end else if (complete && cur_core == CORE_W'(c)) begin
          occupied[c] <= 1'b0;
        end
      end
      if (dispatch) begin
        busy     <= 1'b1;
        cur_core <= head_core;
      end else if (complete) begin
        busy <= 1'b0;
      end
    end
  end

  // R2
  slot_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> occupied[$past(req_core)]);

  // R5
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_core) && $stable(disp_lock)));

  // R6
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> !disp_valid);

  // R7
  done_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> (done_core == $past(disp_core)));

  // R9
  local_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_local) |-> !accept);
endmodule

// File: tb/cs_request_queue_test.sv
module cs_request_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int LW = 4;
  localparam int PW = 16;
  localparam int SW = 16;
  localparam int CW = 2;
  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_local;
  logic [LW-1:0] req_lock = '0;
  logic [PW-1:0] req_pc = '0;
  logic [SW-1:0] req_sp = '0;
  logic [CW-1:0] req_core = '0;
  logic disp_valid, disp_ready = 1'b0;
  logic [LW-1:0] disp_lock;
  logic [PW-1:0] disp_pc;
  logic [SW-1:0] disp_sp;
  logic [CW-1:0] disp_core;
  logic cmpl_valid = 1'b0, cmpl_ready, done_valid, done_ready = 1'b0;
  logic [CW-1:0] done_core;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_request_queue #(.NUM_CORES(NC), .LOCK_W(LW), .PC_W(PW), .SP_W(SW), .FS_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_local(req_local),
    .req_lock(req_lock), .req_pc(req_pc), .req_sp(req_sp), .req_core(req_core),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_lock(disp_lock),
    .disp_pc(disp_pc), .disp_sp(disp_sp), .disp_core(disp_core),
    .cmpl_valid(cmpl_valid), .cmpl_ready(cmpl_ready),
    .done_valid(done_valid), .done_ready(done_ready), .done_core(done_core)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int core, input int lock, input int pc, input int sp);
    @(negedge clk);
    req_valid = 1'b1; req_core = CW'(core); req_lock = LW'(lock);
    req_pc = PW'(pc); req_sp = SW'(sp);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // dispatch the head call, check it, then complete it and check the done reply
  task automatic serve(input int core, input int lock);
    @(negedge clk); #1;
    chk("R3 disp_valid", 32'(disp_valid), 1);
    chk("R3 disp_core order", 32'(disp_core), 32'(core));
    chk("R4 disp_lock", 32'(disp_lock), 32'(lock));
    disp_ready = 1'b1;
    @(posedge clk); #1;
    disp_ready = 1'b0;
    @(negedge clk); #1;
    chk("R6 no dispatch while busy", 32'(disp_valid), 0);
    chk("R7 no done before cmpl", 32'(done_valid), 0);
    req_core = CW'(core); #1;
    chk("R2 slot held while executing", 32'(req_ready), 0);
    cmpl_valid = 1'b1; done_ready = 1'b1; #1;
    chk("R7 done_valid", 32'(done_valid), 1);
    chk("R7 done_core", 32'(done_core), 32'(core));
    chk("R7 cmpl_ready", 32'(cmpl_ready), 1);
    @(posedge clk); #1;
    cmpl_valid = 1'b0; done_ready = 1'b0; #1;
    chk("R2 slot released after done", 32'(req_ready), 1);
  endtask

  task automatic probe_local(input string tag, input int lock, input logic exp);
    @(negedge clk);
    req_valid = 1'b0; req_lock = LW'(lock); #1;
    chk(tag, 32'(req_local), 32'(exp));
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 disp_valid", 32'(disp_valid), 0);
    chk("R1 done_valid", 32'(done_valid), 0);
    for (int c = 0; c < NC; c++) begin
      req_core = CW'(c); #1;
      chk("R1 req_ready", 32'(req_ready), 1);
    end
    for (int l = 0; l < 16; l++) begin
      req_lock = LW'(l); #1;
      chk("R1 req_local", 32'(req_local), 0);
    end
  endtask

  task automatic t_single();
    send(1, 3, 16'h1234, 16'hABCD);
    @(negedge clk); #1;
    chk("R4 disp_pc", 32'(disp_pc), 32'h1234);
    chk("R4 disp_sp", 32'(disp_sp), 32'hABCD);
    serve(1, 3);
  endtask

  task automatic t_order();
    send(2, 1, 16'h0200, 16'h0022);
    send(0, 1, 16'h0000, 16'h0011);
    send(3, 1, 16'h0300, 16'h0033);
    serve(2, 1);
    serve(0, 1);
    serve(3, 1);
  endtask

  task automatic t_slot();
    send(2, 1, 16'h0001, 16'h0002);
    @(negedge clk);
    req_core = 2'd2; #1;
    chk("R2 busy slot not ready", 32'(req_ready), 0);
    req_core = 2'd1; #1;
    chk("R2 other slot ready", 32'(req_ready), 1);
    serve(2, 1);
  endtask

  task automatic t_hold();
    send(0, 2, 16'h0A0A, 16'h0B0B);
    send(3, 2, 16'h0C0C, 16'h0D0D);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R5 held valid", 32'(disp_valid), 1);
      chk("R5 held core", 32'(disp_core), 0);
      chk("R5 held pc", 32'(disp_pc), 32'h0A0A);
    end
    serve(0, 2);
    serve(3, 2);
  endtask

  // lock 6 always waits behind lock 5; lock 5 always arrives alone
  task automatic t_fs_limit();
    for (int r = 0; r < LIMIT; r++) begin
      probe_local("R9 lock6 below limit", 6, 1'b0);
      send(0, 5, 16'h0005, 16'h0050);
      send(1, 6, 16'h0006, 16'h0060);
      serve(0, 5);
      serve(1, 6);
    end
    probe_local("R9 lock6 at limit runs local", 6, 1'b1);
    probe_local("R8 lock5 no wrap below zero", 5, 1'b0);
    send(2, 6, 16'h0066, 16'h0666);
    @(negedge clk); #1;
    chk("R9 local call not dispatched", 32'(disp_valid), 0);
    req_core = 2'd2; #1;
    chk("R9 local call leaves slot free", 32'(req_ready), 1);
    repeat (3) @(negedge clk);
    #1 chk("R9 no done for local call", 32'(done_valid), 0);
  endtask

  task automatic t_fs_down();
    for (int r = 0; r < 2; r++) begin
      send(0, 10, 16'h0010, 16'h0100);
      send(1, 9, 16'h0009, 16'h0090);
      serve(0, 10);
      serve(1, 9);
    end
    send(1, 9, 16'h0009, 16'h0090);
    serve(1, 9);
    send(0, 10, 16'h0010, 16'h0100);
    send(1, 9, 16'h0009, 16'h0090);
    serve(0, 10);
    serve(1, 9);
    probe_local("R8 score decrements on lone call", 9, 1'b0);
    send(0, 10, 16'h0010, 16'h0100);
    send(1, 9, 16'h0009, 16'h0090);
    serve(0, 10);
    serve(1, 9);
    probe_local("R8 score reaches limit after raise", 9, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single();
    t_order();
    t_slot();
    t_hold();
    t_fs_limit();
    t_fs_down();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule